// File: doc/BRIEF.md
# Dual PS/2 Port Register Interface

This block gives a host two identical PS/2 port register sets, one for a keyboard and one for a mouse. Each set has its own 256-byte window. The block sits between a simple register request bus and two abstract byte-stream devices. Each device offers received bytes through a valid/ready queue, takes transmitted bytes through a one-cycle strobe, and raises an interrupt request level. The PS/2 serial line itself is not part of this block.

Each port holds a control byte and a small loopback path. With loopback on, a transmitted byte is held in a one-byte store and read back through the receive register, and the device is never involved. A diagnostic control bit lets the direction bits show up as the data and clock shadow bits of the status byte. The two port interrupts are merged onto a single output line.

Two state machines run the block:

- **Access state machine** (`ps2r_access`).
  - It moves from `ACC_IDLE` to `ACC_RESP` when a read request is accepted.
  - It stays in `ACC_RESP` while reads follow back to back.
  - It returns to `ACC_IDLE` on a write or when no request is present.
- **Loopback state machine** (`ps2r_port`, one per port).
  - It moves from `LB_EMPTY` to `LB_FULL` on a loopback transmit write.
  - A further loopback transmit write while in `LB_FULL` keeps it in `LB_FULL` and replaces the stored byte.
  - It moves from `LB_FULL` to `LB_EMPTY` on a loopback receive read.

Top module: `ps2_dual_regif`

## Requirements
- R1: Address bit 8 selects the port (0 keyboard, 1 mouse). Bits [3:2] select the register. All other address bits are ignored. A read request is answered in the next cycle with `rsp_valid` high for one cycle, and a write produces no response.
- R2: The register at offset 0 reads 0 on the keyboard port and 1 on the mouse port.
- R3: A write to offset 8 stores the control byte, and a read of offset 8 returns it unchanged. The control bits are: bit 0 enable, bit 1 loopback, bit 5 diagnostic, bit 6 data direction, bit 7 clock direction.
- R4: A write to offset 0 or to offset 12 changes no state: control, status and interrupt stay as they were, and no device strobe occurs.
- R5: Status (offset 12) bits 7 and 6 read 1, except that, with diagnostic set, bit 6 reads 0 when data direction is clear and bit 7 reads 0 when clock direction is clear. Status bits 5, 3, 2 and 1 read 0.
- R6: With loopback set, a write to offset 4 stores the byte, sets status bit 0 and raises the port interrupt. It does not strobe `dev_tx_valid`.
- R7: With loopback set, a read of offset 4 returns the stored byte and clears status bit 0 and the port interrupt, without popping the device queue.
- R8: With loopback clear, status bit 0 equals the port's `dev_rx_valid`. A read of offset 4 asserts that port's `dev_rx_ready` during the request cycle and returns `dev_rx_data`, or 0 when `dev_rx_valid` is low.
- R9: With loopback clear, a write to offset 4 asserts that port's `dev_tx_valid` during the request cycle, with the byte on its `dev_tx_data` lane.
- R10: A port's interrupt is its loopback-full state when loopback is set, and its `dev_irq` otherwise. `irq` is the OR of both port interrupts, and status bit 4 shows this OR on both ports.
- R11: Reset clears both control bytes, both loopback states and both interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 9 | Byte address, bit 8 selects the port |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | 8 | Read data |
| dev_rx_valid | input | 2 | Per-port device queue holds a byte |
| dev_rx_data | input | 16 | Per-port head byte, port p on bits [8p+7:8p] |
| dev_rx_ready | output | 2 | Per-port pop strobe |
| dev_tx_valid | output | 2 | Per-port transmit strobe |
| dev_tx_data | output | 16 | Per-port transmit byte, port p on bits [8p+7:8p] |
| dev_irq | input | 2 | Per-port device interrupt request level |
| irq | output | 1 | Merged interrupt |

## Verification
A loopback state machine stuck in the wrong state shows up at once: status bit 0 and `irq` are wrong in the cycle after the transmit write or receive read that should have moved it. A wrong control byte shows up in the next control or status read. It also shows up in the next receive access, because a loopback read then pops or fails to pop the device queue. A fault in the access state machine is visible one cycle after a read, as a missing or extra `rsp_valid`. Random traffic over both ports checks every register read against a model. Directed sequences cover overwriting a full loopback store, reading an empty one, and reset while full.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;

    typedef enum logic [1:0] {
        OFF_ID   = 2'd0,
        OFF_DATA = 2'd1,
        OFF_CTRL = 2'd2,
        OFF_STAT = 2'd3
    } reg_off_e;

    localparam int CB_EN   = 0;
    localparam int CB_LOOP = 1;
    localparam int CB_DIAG = 5;
    localparam int CB_DDIR = 6;
    localparam int CB_CDIR = 7;

    localparam int SB_RXNE = 0;
    localparam int SB_IRQ  = 4;
    localparam int SB_DSHD = 6;
    localparam int SB_CSHD = 7;

    typedef enum logic {
        LB_EMPTY = 1'b0,
        LB_FULL  = 1'b1
    } lb_state_e;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

endpackage

// File: rtl/ps2r_access.sv
module ps2r_access
    import ps2r_pkg::*;
#(
    parameter int NPORTS   = 2,
    parameter int DW       = 8,
    parameter int WIN_BITS = 8,
    localparam int PSEL_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int ADDR_W  = WIN_BITS + PSEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic [NPORTS-1:0]      port_sel,
    output reg_off_e               off,
    output logic                   rd_stb,
    output logic                   wr_stb,
    input  logic [NPORTS*DW-1:0]   port_rdata,
    output logic                   rsp_valid,
    output logic [DW-1:0]          rsp_rdata
);

    acc_state_e state_q, state_d;
    logic [DW-1:0] rdata_q;
    logic [PSEL_W-1:0] pidx;

    assign pidx   = req_addr[WIN_BITS +: PSEL_W];
    assign off    = reg_off_e'(req_addr[3:2]);
    assign rd_stb = req_valid && !req_write;
    assign wr_stb = req_valid && req_write;

    always_comb begin
        for (int i = 0; i < NPORTS; i++) begin
            port_sel[i] = (int'(pidx) == i);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = rd_stb ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = rd_stb ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_stb) begin
                rdata_q <= '0;
                for (int i = 0; i < NPORTS; i++) begin
                    if (port_sel[i]) rdata_q <= port_rdata[i*DW +: DW];
                end
            end
        end
    end

    always_comb begin
        rsp_valid = (state_q == ACC_RESP);
        rsp_rdata = (state_q == ACC_RESP) ? rdata_q : '0;
    end

    assert_rsp_after_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    assert_read_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

// File: rtl/ps2r_port.sv
module ps2r_port
    import ps2r_pkg::*;
#(
    parameter int PORT_ID = 0,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  reg_off_e      off,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          dev_rx_valid,
    input  logic [DW-1:0] dev_rx_data,
    output logic          dev_rx_ready,
    output logic          dev_tx_valid,
    output logic [DW-1:0] dev_tx_data,
    input  logic          dev_irq,
    input  logic          irq_any,
    output logic          port_irq
);

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] lb_buf_q;
    lb_state_e     lb_state_q, lb_state_d;
    logic          loop_on, lb_push, lb_pop, lb_full;
    logic          data_wr, data_rd, ctrl_wr;
    logic [DW-1:0] status;

    assign loop_on = ctrl_q[CB_LOOP];
    assign data_wr = sel && wr_stb && (off == OFF_DATA);
    assign data_rd = sel && rd_stb && (off == OFF_DATA);
    assign ctrl_wr = sel && wr_stb && (off == OFF_CTRL);
    assign lb_push = data_wr && loop_on;
    assign lb_pop  = data_rd && loop_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            lb_buf_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= wdata;
            if (lb_push) lb_buf_q <= wdata;
        end
    end

    always_comb begin
        lb_state_d = lb_state_q;
        unique case (lb_state_q)
            LB_EMPTY: if (lb_push) lb_state_d = LB_FULL;
            LB_FULL:  if (lb_pop)  lb_state_d = LB_EMPTY;
            default:  lb_state_d = LB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lb_state_q <= LB_EMPTY;
        else        lb_state_q <= lb_state_d;
    end

    always_comb begin
        lb_full      = (lb_state_q == LB_FULL);
        port_irq     = loop_on ? lb_full : dev_irq;
        dev_rx_ready = data_rd && !loop_on;
        dev_tx_valid = data_wr && !loop_on;
        dev_tx_data  = dev_tx_valid ? wdata : '0;
    end

    always_comb begin
        status = '0;
        status[SB_DSHD] = !(ctrl_q[CB_DIAG] && !ctrl_q[CB_DDIR]);
        status[SB_CSHD] = !(ctrl_q[CB_DIAG] && !ctrl_q[CB_CDIR]);
        status[SB_RXNE] = loop_on ? lb_full : dev_rx_valid;
        status[SB_IRQ]  = irq_any;
    end

    always_comb begin
        rdata = '0;
        unique case (off)
            OFF_ID:   rdata = DW'(PORT_ID);
            OFF_DATA: begin
                if (loop_on)           rdata = lb_buf_q;
                else if (dev_rx_valid) rdata = dev_rx_data;
                else                   rdata = '0;
            end
            OFF_CTRL: rdata = ctrl_q;
            OFF_STAT: rdata = status;
            default:  rdata = '0;
        endcase
    end

    assert_lb_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lb_push |=> (lb_state_q == LB_FULL) && port_irq);

    assert_lb_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lb_pop |=> (lb_state_q == LB_EMPTY) && !port_irq);

    assert_ctrl_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_q == $past(wdata));

    assert_ctrl_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/ps2_dual_regif.sv
module ps2_dual_regif
    import ps2r_pkg::*;
#(
    parameter int NPORTS   = 2,
    parameter int DW       = 8,
    parameter int WIN_BITS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    input  logic                                  req_write,
    input  logic [WIN_BITS+$clog2(NPORTS)-1:0]    req_addr,
    input  logic [DW-1:0]                         req_wdata,
    output logic                                  rsp_valid,
    output logic [DW-1:0]                         rsp_rdata,
    input  logic [NPORTS-1:0]                     dev_rx_valid,
    input  logic [NPORTS*DW-1:0]                  dev_rx_data,
    output logic [NPORTS-1:0]                     dev_rx_ready,
    output logic [NPORTS-1:0]                     dev_tx_valid,
    output logic [NPORTS*DW-1:0]                  dev_tx_data,
    input  logic [NPORTS-1:0]                     dev_irq,
    output logic                                  irq
);

    logic [NPORTS-1:0]    port_sel;
    logic [NPORTS-1:0]    port_irq;
    logic [NPORTS*DW-1:0] port_rdata;
    reg_off_e             off;
    logic                 rd_stb, wr_stb;
    logic                 irq_any;

    ps2r_access #(
        .NPORTS   (NPORTS),
        .DW       (DW),
        .WIN_BITS (WIN_BITS)
    ) u_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .port_sel   (port_sel),
        .off        (off),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .port_rdata (port_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    assign irq_any = |port_irq;
    assign irq     = irq_any;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        ps2r_port #(
            .PORT_ID (g),
            .DW      (DW)
        ) u_port (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel          (port_sel[g]),
            .rd_stb       (rd_stb),
            .wr_stb       (wr_stb),
            .off          (off),
            .wdata        (req_wdata),
            .rdata        (port_rdata[g*DW +: DW]),
            .dev_rx_valid (dev_rx_valid[g]),
            .dev_rx_data  (dev_rx_data[g*DW +: DW]),
            .dev_rx_ready (dev_rx_ready[g]),
            .dev_tx_valid (dev_tx_valid[g]),
            .dev_tx_data  (dev_tx_data[g*DW +: DW]),
            .dev_irq      (dev_irq[g]),
            .irq_any      (irq_any),
            .port_irq     (port_irq[g])
        );
    end

    assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_rx_ready, dev_tx_valid}));

endmodule

// File: tb/ps2_dual_regif_bench.sv
module ps2_dual_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [8:0]  req_addr;
    logic [7:0]  req_wdata;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [1:0]  dev_rx_valid;
    logic [15:0] dev_rx_data;
    logic [1:0]  dev_rx_ready;
    logic [1:0]  dev_tx_valid;
    logic [15:0] dev_tx_data;
    logic [1:0]  dev_irq;
    logic        irq;

    always #5 clk = ~clk;

    ps2_dual_regif u_ps2_dual_regif (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
        .dev_rx_ready(dev_rx_ready), .dev_tx_valid(dev_tx_valid),
        .dev_tx_data(dev_tx_data), .dev_irq(dev_irq), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_ctrl [2];
    logic [7:0] m_buf  [2];
    logic       m_full [2];

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic m_pirq(int p);
        return m_ctrl[p][1] ? m_full[p] : dev_irq[p];
    endfunction

    function automatic logic m_irq();
        return m_pirq(0) | m_pirq(1);
    endfunction

    function automatic logic [7:0] m_read(int p, int off);
        logic [7:0] s;
        case (off)
            0: return 8'(p);
            1: begin
                if (m_ctrl[p][1]) return m_buf[p];
                return dev_rx_valid[p] ? dev_rx_data[p*8 +: 8] : 8'h00;
            end
            2: return m_ctrl[p];
            default: begin
                s = 8'hC0;
                if (m_ctrl[p][5]) begin
                    if (!m_ctrl[p][6]) s[6] = 1'b0;
                    if (!m_ctrl[p][7]) s[7] = 1'b0;
                end
                s[0] = m_ctrl[p][1] ? m_full[p] : dev_rx_valid[p];
                s[4] = m_irq();
                return s;
            end
        endcase
    endfunction

    function automatic string rd_tag(int off);
        case (off)
            0: return "R2 id read";
            1: return "R7/R8 data read";
            2: return "R3 control read";
            default: return "R5/R10 status read";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 2; p++) begin
            m_ctrl[p] = 8'h00;
            m_buf[p]  = 8'h00;
            m_full[p] = 1'b0;
        end
    endtask

    task automatic access(int p, int off, bit wr, logic [7:0] d);
        logic [1:0] exp_rdy, exp_txv;
        logic [7:0] exp_rd;
        bit loop_on;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {p[0], 4'($urandom), off[1:0], 2'($urandom)};
        req_wdata = d;
        #1;
        loop_on = m_ctrl[p][1];
        exp_rdy = '0;
        exp_txv = '0;
        if (!wr && off == 1 && !loop_on) exp_rdy[p] = 1'b1;
        if (wr && off == 1 && !loop_on)  exp_txv[p] = 1'b1;
        chk(dev_rx_ready == exp_rdy, "R8/R7 pop strobe", dev_rx_ready, exp_rdy);
        chk(dev_tx_valid == exp_txv, "R9/R6/R4 tx strobe", dev_tx_valid, exp_txv);
        if (exp_txv[p]) chk(dev_tx_data[p*8 +: 8] == d, "R9 tx byte", dev_tx_data[p*8 +: 8], d);
        exp_rd = m_read(p, off);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        if (!wr) begin
            chk(rsp_valid == 1'b1, "R1 response valid", rsp_valid, 1);
            chk(rsp_rdata == exp_rd, rd_tag(off), rsp_rdata, exp_rd);
        end else begin
            chk(rsp_valid == 1'b0, "R1 no write response", rsp_valid, 0);
            if (off == 2) m_ctrl[p] = d;
            if (off == 1 && loop_on) begin
                m_buf[p]  = d;
                m_full[p] = 1'b1;
            end
        end
        if (!wr && off == 1 && loop_on) m_full[p] = 1'b0;
        chk(irq == m_irq(), "R10 merged irq", irq, m_irq());
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr = '0;
        req_wdata = '0;
        dev_rx_valid = '0;
        dev_rx_data = '0;
        dev_irq = '0;
        void'($urandom(32'd1234));
        do_reset();

        // R11 reset state
        chk(irq == 1'b0, "R11 irq after reset", irq, 0);
        chk(rsp_valid == 1'b0, "R11 no response after reset", rsp_valid, 0);
        access(0, 2, 0, 8'h00);
        access(1, 2, 0, 8'h00);
        access(0, 3, 0, 8'h00);
        access(0, 0, 0, 8'h00);
        access(1, 0, 0, 8'h00);

        // R3 control readback and R5 diagnostic shadows
        access(0, 2, 1, 8'hA3);
        access(0, 2, 0, 8'h00);
        access(0, 3, 0, 8'h00);
        access(1, 2, 1, 8'h60);
        access(1, 3, 0, 8'h00);
        access(1, 2, 1, 8'h20);
        access(1, 3, 0, 8'h00);

        // R4 ignored writes
        access(0, 0, 1, 8'hFF);
        access(0, 3, 1, 8'h55);
        access(0, 2, 0, 8'h00);
        access(0, 3, 0, 8'h00);

        // R6/R7 loopback fill, overwrite, drain, empty read
        access(1, 2, 1, 8'h02);
        access(1, 1, 1, 8'h11);
        access(1, 1, 1, 8'h7E);
        access(0, 3, 0, 8'h00);
        access(1, 1, 0, 8'h00);
        access(1, 1, 0, 8'h00);
        access(1, 3, 0, 8'h00);

        // R8/R9/R10 device path
        dev_rx_valid = 2'b01;
        dev_rx_data  = 16'h00C4;
        dev_irq      = 2'b01;
        access(0, 2, 1, 8'h01);
        access(0, 3, 0, 8'h00);
        access(0, 1, 0, 8'h00);
        access(0, 1, 1, 8'h5A);
        dev_rx_valid = 2'b00;
        dev_irq = 2'b00;
        access(0, 1, 0, 8'h00);

        // R11 reset while loopback full
        access(0, 2, 1, 8'h02);
        access(0, 1, 1, 8'h99);
        do_reset();
        #1;
        chk(irq == 1'b0, "R11 irq cleared", irq, 0);
        access(0, 3, 0, 8'h00);
        access(0, 2, 0, 8'h00);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            dev_rx_valid = 2'($urandom);
            dev_rx_data  = 16'($urandom);
            dev_irq      = 2'($urandom);
            access(int'($urandom % 2), int'($urandom % 4), 1'($urandom),
                   ($urandom % 3 == 0) ? 8'($urandom) & 8'hE3 : 8'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule